// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block sits behind a parallel NOR-flash style bus and turns plain bus writes into a multi-cycle command protocol. The low byte of each write is read as an opcode or a confirm code. A write-cycle counter, the active command and an 8-bit status register decide what the next write means and what a read returns. A read can return one of four things: the storage array, the status byte, identification codes or a query table describing the geometry.

The storage is a small on-chip array of bus-width words, divided into equal power-of-two sectors. The block supports:

- single-word program;
- sector erase, which needs a confirm write;
- status clear and status read;
- identification and query read modes;
- a two-write lock/unlock sequence that protects nothing;
- a counted buffered write.

A read-only strap blocks all changes to the array and reports each blocked operation through status error bits. A bus word can hold several identical devices side by side (parameter BANK_BYTES / DEV_BYTES). Status, identification and query data are copied into every device lane of the returned word.

Top module: `pflash_cmd_unit`

## Requirements
- R1: After reset, every array word reads all ones, the block is in array-read mode with the cycle counter at zero, and the status byte is 0x80.
- R2: A first-cycle write of 0xFF, 0xF0 or 0x00 puts the block in array-read mode, so later reads return array words.
- R3: A first-cycle write of 0x10 or 0x40 arms a program. The next write stores its full data word at its own word address and sets status bit 7. Reads then return status until another command is given.
- R4: A first-cycle write of 0x20 or 0x28 arms an erase. A second write of 0xD0 fills every word of the sector holding that second write's address with all ones. A second write of 0xFF, or of any other value, returns to array-read mode with nothing erased.
- R5: While the read-only strap is high, the array never changes. A blocked program sets status bit 4, a blocked erase sets status bit 5, and bit 7 is set in both cases.
- R6: A first-cycle write of 0x50 clears the status byte to 0x00 and returns to array-read mode.
- R7: After a first-cycle write of 0x70, a read returns the status byte zero-extended into each DEV_BYTES-wide lane of the bus word. With two byte-wide devices and status 0x80, the read gives 0x8080.
- R8: After 0x90, a read whose word address has its low 8 bits equal to 0 returns MAKER_ID in every lane. If those bits equal 1, the read returns PART_ID in every lane. Any other address returns 0.
- R9: After 0x98, a read at word address A returns query byte Q(A) in every lane. The defined entries are:
  - 0x10, 0x11, 0x12: 0x51, 0x52, 0x59;
  - 0x13: 0x01;
  - 0x15: 0x31;
  - 0x27: log2 of the per-device size in bytes;
  - 0x2C: 0x01;
  - 0x2D and 0x2E: the sector count minus 1, low byte first;
  - 0x2F and 0x30: the per-device sector size in bytes divided by 256, low byte first.

  Every other entry is 0. Query mode ignores every write except 0xFF, which returns to array-read mode.
- R10: A first-cycle write of 0x60 followed by 0xD0 or 0x01 ends with status bit 7 set and reads returning status. Any other second value returns to array-read mode.
- R11: 0xE8 starts a buffered write. The next write gives a count N, made of its low DEV_BYTES*8 bits. The following N+1 writes store their data at their own addresses. Then 0xD0 completes the sequence, and reads return status. Any other final value returns to array-read mode, and the stored words are kept.
- R12: A first-cycle write with an unrecognised opcode returns to array-read mode with the cycle counter at zero.
- R13: Read data is registered. It appears on the clock edge that samples the read strobe and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| rd_stb | input | 1 | One-cycle read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 8*BANK_BYTES | Write data or command byte (low 8 bits) |
| ro_strap | input | 1 | Read-only strap |
| rdata | output | 8*BANK_BYTES | Registered read data |

## Verification
The bench first programs every word with a distinct pattern. It then erases sectors using addresses that sit in the middle of the sector, so a design that does not align the address down, or that clears a neighbouring sector, leaves mismatched words. It writes the buffered-write count with bits set above the device width: if the count is not masked, the confirm write lands in the array as data. The bench sweeps every address in identification and query modes against tables it computes itself, which exposes a wrong lane copy or a missing query entry. It also checks that a blocked program or erase sets the right error bit while leaving the array intact.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   localparam logic [7:0] OP_ARRAY0    = 8'h00;
   localparam logic [7:0] OP_ARRAY     = 8'hFF;
   localparam logic [7:0] OP_ARRAY_ALT = 8'hF0;
   localparam logic [7:0] OP_PROG_A    = 8'h10;
   localparam logic [7:0] OP_PROG_B    = 8'h40;
   localparam logic [7:0] OP_ERASE_A   = 8'h20;
   localparam logic [7:0] OP_ERASE_B   = 8'h28;
   localparam logic [7:0] OP_CLEAR     = 8'h50;
   localparam logic [7:0] OP_LOCK      = 8'h60;
   localparam logic [7:0] OP_STATUS    = 8'h70;
   localparam logic [7:0] OP_IDENT     = 8'h90;
   localparam logic [7:0] OP_QUERY     = 8'h98;
   localparam logic [7:0] OP_BUFFER    = 8'hE8;
   localparam logic [7:0] OP_CONFIRM   = 8'hD0;
   localparam logic [7:0] OP_LOCK_ALT  = 8'h01;

   localparam int ST_READY     = 7;
   localparam int ST_ERASE_ERR = 5;
   localparam int ST_PROG_ERR  = 4;

   typedef enum logic [1:0] {
      SRC_ARRAY  = 2'd0,
      SRC_STATUS = 2'd1,
      SRC_IDENT  = 2'd2,
      SRC_QUERY  = 2'd3
   } rd_src_e;

   function automatic rd_src_e src_of(input logic [7:0] cmd);
      case (cmd)
         OP_ARRAY0: src_of = SRC_ARRAY;
         OP_IDENT:  src_of = SRC_IDENT;
         OP_QUERY:  src_of = SRC_QUERY;
         default:   src_of = SRC_STATUS;
      endcase
   endfunction

   function automatic logic lead_known(input logic [7:0] op);
      case (op)
         OP_ARRAY0, OP_ARRAY, OP_ARRAY_ALT, OP_PROG_A, OP_PROG_B,
         OP_ERASE_A, OP_ERASE_B, OP_CLEAR, OP_LOCK, OP_STATUS,
         OP_IDENT, OP_QUERY, OP_BUFFER: lead_known = 1'b1;
         default: lead_known = 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] query_byte(input int idx, input int size_log2,
                                             input int nsec, input int sec_bytes);
      int v;
      case (idx)
         'h10: v = 'h51;
         'h11: v = 'h52;
         'h12: v = 'h59;
         'h13: v = 'h01;
         'h15: v = 'h31;
         'h27: v = size_log2;
         'h2C: v = 'h01;
         'h2D: v = nsec - 1;
         'h2E: v = (nsec - 1) >> 8;
         'h2F: v = sec_bytes >> 8;
         'h30: v = sec_bytes >> 16;
         default: v = 0;
      endcase
      query_byte = 8'(v);
   endfunction

endpackage

// File: rtl/pfc_sequencer.sv
module pfc_sequencer
   import pfc_pkg::*;
#(
   parameter int DEV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [DEV_W-1:0] wr_word,
   input  logic             ro_strap,
   output logic [7:0]       cmd_q,
   output logic [7:0]       status_q,
   output logic             prog_en,
   output logic             erase_en
);

   logic [1:0]       wcyc_q, wcyc_d;
   logic [7:0]       cmd_d, status_d;
   logic [DEV_W-1:0] cnt_q, cnt_d;
   logic [7:0]       op;

   assign op = wr_word[7:0];

   always_comb begin
      wcyc_d   = wcyc_q;
      cmd_d    = cmd_q;
      status_d = status_q;
      cnt_d    = cnt_q;
      prog_en  = 1'b0;
      erase_en = 1'b0;
      if (wr_stb) begin
         case (wcyc_q)
            2'd0: begin
               case (op)
                  OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B,
                  OP_LOCK, OP_QUERY: begin
                     wcyc_d = 2'd1;
                     cmd_d  = op;
                  end
                  OP_BUFFER: begin
                     wcyc_d = 2'd1;
                     cmd_d  = op;
                     status_d[ST_READY] = 1'b1;
                  end
                  OP_STATUS, OP_IDENT: begin
                     cmd_d = op;
                  end
                  OP_CLEAR: begin
                     status_d = 8'h00;
                     cmd_d    = OP_ARRAY0;
                  end
                  default: begin
                     cmd_d = OP_ARRAY0;
                  end
               endcase
            end
            2'd1: begin
               case (cmd_q)
                  OP_PROG_A, OP_PROG_B: begin
                     if (ro_strap) status_d[ST_PROG_ERR] = 1'b1;
                     else          prog_en = 1'b1;
                     status_d[ST_READY] = 1'b1;
                     wcyc_d = 2'd0;
                  end
                  OP_ERASE_A, OP_ERASE_B: begin
                     wcyc_d = 2'd0;
                     if (op == OP_CONFIRM) begin
                        if (ro_strap) status_d[ST_ERASE_ERR] = 1'b1;
                        else          erase_en = 1'b1;
                        status_d[ST_READY] = 1'b1;
                     end else begin
                        cmd_d = OP_ARRAY0;
                     end
                  end
                  OP_LOCK: begin
                     wcyc_d = 2'd0;
                     if (op == OP_CONFIRM || op == OP_LOCK_ALT)
                        status_d[ST_READY] = 1'b1;
                     else
                        cmd_d = OP_ARRAY0;
                  end
                  OP_QUERY: begin
                     if (op == OP_ARRAY) begin
                        wcyc_d = 2'd0;
                        cmd_d  = OP_ARRAY0;
                     end
                  end
                  OP_BUFFER: begin
                     cnt_d  = wr_word;
                     wcyc_d = 2'd2;
                  end
                  default: begin
                     wcyc_d = 2'd0;
                     cmd_d  = OP_ARRAY0;
                  end
               endcase
            end
            2'd2: begin
               if (cmd_q == OP_BUFFER) begin
                  if (ro_strap) status_d[ST_PROG_ERR] = 1'b1;
                  else          prog_en = 1'b1;
                  status_d[ST_READY] = 1'b1;
                  if (cnt_q == '0) wcyc_d = 2'd3;
                  cnt_d = cnt_q - 1'b1;
               end else begin
                  wcyc_d = 2'd0;
                  cmd_d  = OP_ARRAY0;
               end
            end
            default: begin
               wcyc_d = 2'd0;
               if (cmd_q == OP_BUFFER && op == OP_CONFIRM)
                  status_d[ST_READY] = 1'b1;
               else
                  cmd_d = OP_ARRAY0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcyc_q   <= 2'd0;
         cmd_q    <= OP_ARRAY0;
         status_q <= 8'h80;
         cnt_q    <= '0;
      end else begin
         wcyc_q   <= wcyc_d;
         cmd_q    <= cmd_d;
         status_q <= status_d;
         cnt_q    <= cnt_d;
      end
   end

   p_unknown_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wcyc_q == 2'd0 && !lead_known(op)) |=> (cmd_q == OP_ARRAY0 && wcyc_q == 2'd0));

   p_clear_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wcyc_q == 2'd0 && op == OP_CLEAR) |=> (status_q == 8'h00 && cmd_q == OP_ARRAY0));

   p_prog_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wcyc_q == 2'd1 && (cmd_q == OP_PROG_A || cmd_q == OP_PROG_B))
      |=> (status_q[ST_READY] && wcyc_q == 2'd0));

   p_ro_prog_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && ro_strap && wcyc_q == 2'd1 && (cmd_q == OP_PROG_A || cmd_q == OP_PROG_B))
      |=> status_q[ST_PROG_ERR]);

   p_ro_erase_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && ro_strap && wcyc_q == 2'd1 && op == OP_CONFIRM &&
       (cmd_q == OP_ERASE_A || cmd_q == OP_ERASE_B))
      |=> (status_q[ST_ERASE_ERR] && status_q[ST_READY]));

   p_query_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wcyc_q == 2'd1 && cmd_q == OP_QUERY && op != OP_ARRAY) |=> (cmd_q == OP_QUERY));

   p_buffer_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wcyc_q == 2'd3 && op != OP_CONFIRM) |=> (cmd_q == OP_ARRAY0 && wcyc_q == 2'd0));

   p_single_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_en && erase_en));

endmodule

// File: rtl/pfc_array.sv
module pfc_array #(
   parameter int DW           = 16,
   parameter int SECTOR_WORDS = 8,
   parameter int NUM_SECTORS  = 4,
   parameter int IDX_W        = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prog_en,
   input  logic             erase_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rd_word
);

   localparam int SB    = $clog2(SECTOR_WORDS);
   localparam int SECB  = IDX_W - SB;
   localparam int DEPTH = SECTOR_WORDS * NUM_SECTORS;

   logic [DEPTH-1:0][DW-1:0] words;
   logic [SECB-1:0]          hit_sec;

   assign hit_sec = idx[IDX_W-1:SB];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam logic [SECB-1:0]  MY_SEC = SECB'(w >> SB);
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(w);
      logic [DW-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '1;
         else if (erase_en && hit_sec == MY_SEC)
            word_q <= '1;
         else if (prog_en && idx == MY_IDX)
            word_q <= wdata;
      end
      assign words[w] = word_q;
   end

   assign rd_word = words[idx];

   p_erase_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      erase_en |=> (words[{$past(hit_sec), {SB{1'b0}}}] == {DW{1'b1}}));

   p_prog_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_en && !erase_en) |=> (words[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/pfc_readmux.sv
module pfc_readmux
   import pfc_pkg::*;
#(
   parameter int          BANK_BYTES    = 2,
   parameter int          DEV_BYTES     = 1,
   parameter int          ADDR_W        = 7,
   parameter logic [31:0] MAKER_ID      = 32'h5A,
   parameter logic [31:0] PART_ID       = 32'hC3,
   parameter int          QRY_SIZE_LOG2 = 5,
   parameter int          QRY_SECTORS   = 4,
   parameter int          QRY_SEC_BYTES = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_stb,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [7:0]              cmd,
   input  logic [7:0]              status,
   input  logic [8*BANK_BYTES-1:0] arr_word,
   output logic [8*BANK_BYTES-1:0] rdata
);

   localparam int DW    = 8 * BANK_BYTES;
   localparam int DEV_W = 8 * DEV_BYTES;
   localparam int LANES = BANK_BYTES / DEV_BYTES;
   localparam int OFFB  = (ADDR_W < 8) ? ADDR_W : 8;

   rd_src_e          src;
   logic [OFFB-1:0]  id_off;
   logic [DEV_W-1:0] id_dev, qry_dev, st_dev;
   logic [DW-1:0]    id_bus, qry_bus, st_bus, rd_next;
   logic [7:0]       qbyte;

   assign src    = src_of(cmd);
   assign id_off = addr[OFFB-1:0];
   assign qbyte  = query_byte(int'(addr), QRY_SIZE_LOG2, QRY_SECTORS, QRY_SEC_BYTES);
   assign st_dev = DEV_W'(status);
   assign qry_dev = DEV_W'(qbyte);

   always_comb begin
      if (id_off == OFFB'(0))      id_dev = MAKER_ID[DEV_W-1:0];
      else if (id_off == OFFB'(1)) id_dev = PART_ID[DEV_W-1:0];
      else                         id_dev = '0;
   end

   if (LANES == 1) begin : g_single
      assign st_bus  = st_dev;
      assign id_bus  = id_dev;
      assign qry_bus = qry_dev;
   end else begin : g_multi
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign st_bus[l*DEV_W +: DEV_W]  = st_dev;
         assign id_bus[l*DEV_W +: DEV_W]  = id_dev;
         assign qry_bus[l*DEV_W +: DEV_W] = qry_dev;
      end
   end

   always_comb begin
      case (src)
         SRC_ARRAY:  rd_next = arr_word;
         SRC_IDENT:  rd_next = id_bus;
         SRC_QUERY:  rd_next = qry_bus;
         default:    rd_next = st_bus;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (rd_stb) rdata <= rd_next;
   end

   p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rdata));

   p_array_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && cmd == OP_ARRAY0) |=> (rdata == $past(arr_word)));

endmodule

// File: rtl/pflash_cmd_unit.sv
module pflash_cmd_unit
   import pfc_pkg::*;
#(
   parameter int          BANK_BYTES   = 2,
   parameter int          DEV_BYTES    = 1,
   parameter int          ADDR_W       = 7,
   parameter int          SECTOR_WORDS = 8,
   parameter int          NUM_SECTORS  = 4,
   parameter logic [31:0] MAKER_ID     = 32'h5A,
   parameter logic [31:0] PART_ID      = 32'hC3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_stb,
   input  logic                    rd_stb,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [8*BANK_BYTES-1:0] wdata,
   input  logic                    ro_strap,
   output logic [8*BANK_BYTES-1:0] rdata
);

   localparam int DW         = 8 * BANK_BYTES;
   localparam int DEV_W      = 8 * DEV_BYTES;
   localparam int IDX_W      = $clog2(SECTOR_WORDS) + $clog2(NUM_SECTORS);
   localparam int DEV_SEC_B  = SECTOR_WORDS * DEV_BYTES;
   localparam int DEV_SIZE_L = $clog2(DEV_SEC_B * NUM_SECTORS);

   if (DEV_BYTES < 1 || DEV_BYTES > 4) begin : g_bad_dev
      $error("DEV_BYTES must be 1 to 4");
   end
   if (BANK_BYTES < DEV_BYTES || (BANK_BYTES % DEV_BYTES) != 0) begin : g_bad_bank
      $error("BANK_BYTES must be a multiple of DEV_BYTES");
   end
   if (SECTOR_WORDS < 2 || (SECTOR_WORDS & (SECTOR_WORDS - 1)) != 0) begin : g_bad_sec
      $error("SECTOR_WORDS must be a power of two, at least 2");
   end
   if (NUM_SECTORS < 2 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0) begin : g_bad_nsec
      $error("NUM_SECTORS must be a power of two, at least 2");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("ADDR_W too small for the array");
   end

   logic [7:0]    cmd_q, status_q;
   logic          prog_en, erase_en;
   logic [DW-1:0] arr_word;

   pfc_sequencer #(.DEV_W(DEV_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wr_word  (wdata[DEV_W-1:0]),
      .ro_strap (ro_strap),
      .cmd_q    (cmd_q),
      .status_q (status_q),
      .prog_en  (prog_en),
      .erase_en (erase_en)
   );

   pfc_array #(
      .DW           (DW),
      .SECTOR_WORDS (SECTOR_WORDS),
      .NUM_SECTORS  (NUM_SECTORS),
      .IDX_W        (IDX_W)
   ) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_en  (prog_en),
      .erase_en (erase_en),
      .idx      (addr[IDX_W-1:0]),
      .wdata    (wdata),
      .rd_word  (arr_word)
   );

   pfc_readmux #(
      .BANK_BYTES    (BANK_BYTES),
      .DEV_BYTES     (DEV_BYTES),
      .ADDR_W        (ADDR_W),
      .MAKER_ID      (MAKER_ID),
      .PART_ID       (PART_ID),
      .QRY_SIZE_LOG2 (DEV_SIZE_L),
      .QRY_SECTORS   (NUM_SECTORS),
      .QRY_SEC_BYTES (DEV_SEC_B)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stb   (rd_stb),
      .addr     (addr),
      .cmd      (cmd_q),
      .status   (status_q),
      .arr_word (arr_word),
      .rdata    (rdata)
   );

endmodule

// File: tb/sim_pflash_cmd_unit.sv
module sim_pflash_cmd_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic        rd_stb = 1'b0;
   logic [6:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic        ro_strap = 1'b0;
   logic [15:0] rdata;

   int total = 0;
   int bad = 0;
   logic [15:0] exp_mem [32];

   always #5 clk = ~clk;

   pflash_cmd_unit u0 (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .addr(addr), .wdata(wdata), .ro_strap(ro_strap), .rdata(rdata)
   );

   function automatic logic [15:0] pat(input int i);
      pat = 16'((i * 16'h0101) ^ 16'h5A3C);
   endfunction

   function automatic logic [7:0] qexp(input int a);
      case (a)
         'h10: qexp = 8'h51;
         'h11: qexp = 8'h52;
         'h12: qexp = 8'h59;
         'h13: qexp = 8'h01;
         'h15: qexp = 8'h31;
         'h27: qexp = 8'd5;     // 8 bytes per sector per device * 4 sectors = 32
         'h2C: qexp = 8'h01;
         'h2D: qexp = 8'd3;
         default: qexp = 8'h00; // includes 0x2E, 0x2F, 0x30 (all zero here)
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      addr = 7'(a); wdata = d; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      @(negedge clk);
      addr = 7'(a); rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      d = rdata;
   endtask

   task automatic check_array(input string tag);
      logic [15:0] v;
      for (int i = 0; i < 32; i++) begin
         rd(i, v);
         chk(tag, v, exp_mem[i]);
      end
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      for (int i = 0; i < 32; i++) exp_mem[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents and status
      check_array("R1 reset array");
      wr(0, 16'h0070);
      rd(0, v); chk("R1 reset status", v, 16'h8080);
      wr(0, 16'h00FF);

      // R3: program every word, alternating opcodes
      for (int i = 0; i < 32; i++) begin
         wr(i, (i % 2 == 0) ? 16'h0040 : 16'h0010);
         wr(i, pat(i));
         exp_mem[i] = pat(i);
         if (i % 8 == 3) begin
            rd(i, v); chk("R3 status after program", v, 16'h8080);
         end
      end
      wr(0, 16'h00FF);
      check_array("R3 program readback");

      // R4: erase sector 1 via an address in the middle
      wr(9, 16'h0020);
      wr(13, 16'h00D0);
      for (int i = 8; i < 16; i++) exp_mem[i] = 16'hFFFF;
      rd(0, v); chk("R4 status after erase", v, 16'h8080);
      wr(0, 16'h00FF);
      check_array("R4 erase sector1");
      // R4: abort with FF, then illegal confirm
      wr(17, 16'h0028); wr(17, 16'h00FF);
      rd(17, v); chk("R4 abort keeps data", v, exp_mem[17]);
      wr(17, 16'h0020); wr(17, 16'h0077);
      rd(17, v); chk("R4 illegal confirm array mode", v, exp_mem[17]);
      // R4: erase sector 3 with the alternate opcode
      wr(30, 16'h0028); wr(25, 16'h00D0);
      for (int i = 24; i < 32; i++) exp_mem[i] = 16'hFFFF;
      wr(0, 16'h00FF);
      check_array("R4 erase sector3");

      // R5: read-only strap
      ro_strap = 1'b1;
      wr(3, 16'h0040); wr(3, 16'h1111);
      rd(3, v); chk("R5 program error status", v, 16'h9090);
      wr(0, 16'h0020); wr(0, 16'h00D0);
      rd(0, v); chk("R5 erase error status", v, 16'hB0B0);
      wr(0, 16'h00FF);
      rd(3, v); chk("R5 no program", v, exp_mem[3]);
      rd(0, v); chk("R5 no erase", v, exp_mem[0]);
      rd(5, v); chk("R5 no erase sector0", v, exp_mem[5]);

      // R6: clear status
      wr(0, 16'h0050);
      rd(1, v); chk("R6 array after clear", v, exp_mem[1]);
      wr(0, 16'h0070);
      rd(0, v); chk("R6 status cleared", v, 16'h0000);
      ro_strap = 1'b0;
      wr(2, 16'h0040); wr(2, 16'hBEEF);
      exp_mem[2] = 16'hBEEF;
      rd(2, v); chk("R3 ready set after clear", v, 16'h8080);
      wr(0, 16'h00FF);
      rd(2, v); chk("R3 program stored", v, 16'hBEEF);

      // R7: status lanes
      wr(0, 16'h0070);
      rd(40, v); chk("R7 status replicated", v, 16'h8080);

      // R8: identification sweep
      wr(0, 16'h0090);
      for (int a = 0; a < 128; a++) begin
         rd(a, v);
         chk("R8 ident", v, (a == 0) ? 16'h5A5A : (a == 1) ? 16'hC3C3 : 16'h0000);
      end
      wr(0, 16'h0070);
      rd(0, v); chk("R7 status from ident mode", v, 16'h8080);
      wr(0, 16'h00FF);

      // R9: query sweep
      wr(0, 16'h0098);
      for (int a = 0; a < 128; a++) begin
         rd(a, v);
         chk("R9 query", v, {qexp(a), qexp(a)});
      end
      wr(0, 16'h0070);
      wr(0, 16'h0040);
      rd(17, v); chk("R9 query ignores writes", v, 16'h5252);
      wr(0, 16'h00FF);
      rd(17, v); chk("R9 query exit", v, exp_mem[17]);

      // R10: lock sequences
      wr(0, 16'h0060); wr(0, 16'h00D0);
      rd(0, v); chk("R10 lock D0", v, 16'h8080);
      wr(0, 16'h0060); wr(0, 16'h0001);
      rd(0, v); chk("R10 lock 01", v, 16'h8080);
      wr(0, 16'h0060); wr(0, 16'h0033);
      rd(5, v); chk("R10 bad lock array mode", v, exp_mem[5]);

      // R11: buffered write, count masked to device width
      wr(4, 16'h00E8);
      wr(4, 16'h0102);
      wr(4, 16'hA1A1); wr(5, 16'hB2B2); wr(6, 16'hC3C3);
      exp_mem[4] = 16'hA1A1; exp_mem[5] = 16'hB2B2; exp_mem[6] = 16'hC3C3;
      wr(7, 16'h00D0);
      rd(0, v); chk("R11 status after confirm", v, 16'h8080);
      wr(0, 16'h00FF);
      check_array("R11 buffer data");
      // R11: abort at confirm
      wr(20, 16'h00E8); wr(20, 16'h0000); wr(20, 16'h7E7E);
      exp_mem[20] = 16'h7E7E;
      wr(21, 16'h1234);
      rd(20, v); chk("R11 abort keeps data", v, 16'h7E7E);
      rd(21, v); chk("R11 abort array mode", v, exp_mem[21]);

      // R12: unknown opcode
      wr(0, 16'h0070);
      wr(0, 16'h0033);
      rd(6, v); chk("R12 unknown to array", v, exp_mem[6]);

      // R2: alternate read-array opcodes
      wr(0, 16'h0070); wr(0, 16'h00F0);
      rd(18, v); chk("R2 F0 array", v, exp_mem[18]);
      wr(0, 16'h0090); wr(0, 16'h0000);
      rd(19, v); chk("R2 00 array", v, exp_mem[19]);

      // R13: rdata holds without a read strobe
      rd(5, v);
      @(negedge clk); addr = 7'd6;
      @(negedge clk);
      chk("R13 rdata hold", rdata, exp_mem[5]);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule